// File: doc/BRIEF.md
# March-Test Memory Self-Test Sequencer

This block runs one of five built-in march algorithms over a synchronous single-port RAM. Each algorithm is a fixed list of elements. An element has an address direction and one or two operations. Each operation is a write or a read-and-compare, and it uses the data background or its bitwise inverse. The sequencer applies all operations of an element to one cell before it moves to the next cell. It walks an address window that the caller programs.

A run begins with a one-cycle `start` pulse. At that pulse the caller supplies the algorithm number, the lower and upper addresses of the window, the background word and an opening command code. The opening command code guards against a run started with the wrong intent. The engine stops at the first read whose data differs from the expected word. When it stops, the element index, the operation index, the address and the command of the failing step stay on the step outputs. A test controller can then name the faulty cell and the phase that exposed it.

Top module: `mbist_seq`

## Requirements
- R1: `algo_sel` picks the algorithm, and each algorithm applies these elements in this order:
  - 0 = Init: up(wD)
  - 1 = Read-and-check: up(rD)
  - 2 = Scan: up(wD); up(rD); up(wI); up(rI)
  - 3 = MATS+: up(wD); up(rD,wI); down(rI,wD)
  - 4 = March C-: up(wD); up(rD,wI); up(rI,wD); down(rD,wI); down(rI,wD); down(rD)
  - D is `background` and I is `~background`.
- R2: The operations inside one element all act on the same address, back to back. The address changes only after the last operation of the element.
- R3: An ascending element starts at `start_addr` and counts up to `end_addr`. A descending element starts at `end_addr` and counts down to `start_addr`. `mem_addr` never leaves that window while busy.
- R4: Each read is compared with the element's expected word, which is D or I.
- R5: `init_cmd` must be 4'h3 (read-and-check) for algorithm 1 and 4'h1 (write) for algorithms 0, 2, 3 and 4. Any other code, or an `algo_sel` above 4, sets `cmd_err`, raises neither `done` nor `busy`, and causes no memory access.
- R6: On the first mismatch the engine sets `fail`, drops `busy` and stops all access. It then holds `step_elem`, `step_op` (0 = first operation of the element), `step_addr` and `step_cmd` (4'h1 = write, 4'h3 = read-and-check) at the values of the failing read until the next start.
- R7: A full passing run makes exactly (writes per cell × N) writes and (reads per cell × N) reads, where N = `end_addr - start_addr + 1`.
- R8: `busy` rises the cycle after an accepted start and stays high until completion or halt. `done`, `fail` and `cmd_err` are sticky and are cleared by the next start. `start` is ignored while busy.
- R9: A write occupies one cycle. A read occupies two cycles: the issue cycle, then a compare cycle against `mem_rdata`, which arrives one cycle after `mem_re`. A passing Scan over N cells therefore stays busy for 6N cycles.
- R10: If `start_addr > end_addr` with a valid command, `done` is set at once and no access is made.
- R11: `mem_we` and `mem_re` are never high together, and neither is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle run request |
| algo_sel | input | 3 | Algorithm number (0..4) |
| start_addr | input | AW | Lower address of the window |
| end_addr | input | AW | Upper address of the window |
| background | input | DW | Data background D |
| init_cmd | input | 4 | Opening command code |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable (data one cycle later) |
| mem_rdata | input | DW | RAM read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished without mismatch (sticky) |
| fail | output | 1 | Run halted on a mismatch (sticky) |
| cmd_err | output | 1 | Start rejected (sticky) |
| step_elem | output | 3 | Current or failing element index |
| step_op | output | 1 | Current or failing operation index |
| step_addr | output | AW | Current or failing address |
| step_cmd | output | 4 | Command of the current or failing operation |

## Verification
Some properties are checked on every cycle:
- Writes and reads never overlap, and there is no access while idle.
- The address stays inside the latched window and holds still between operations of one element.
- A compare cycle always follows a read issue.
- `done` and `fail` never coexist.
- The step outputs freeze after a halt.

Other behaviour can only be shown by the bench's scenarios:
- Each algorithm applies its element list and makes the right number of operations.
- A stuck bit halts the run at the expected element, operation and address.
- Descending elements visit the top of the window first, which the read count before a halt exposes.
- The engine rejects bad commands and handles empty windows correctly.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [2:0] {
        ALG_INIT   = 3'd0,
        ALG_RDCHK  = 3'd1,
        ALG_SCAN   = 3'd2,
        ALG_MATS   = 3'd3,
        ALG_MARCHC = 3'd4
    } algo_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_CHECK = 2'd2
    } state_e;

    localparam logic [3:0] CMD_WR    = 4'h1;
    localparam logic [3:0] CMD_RDCHK = 4'h3;
    localparam int         ELEM_W    = 3;

    // one operation: read-compare flag and inverted-data flag
    typedef struct packed {
        logic rd;
        logic inv;
    } op_t;

    // one march element: direction, second-operation flag, two operations
    typedef struct packed {
        logic down;
        logic two;
        op_t  op0;
        op_t  op1;
    } elem_t;

    localparam op_t OP_WD = 2'b00;
    localparam op_t OP_WI = 2'b01;
    localparam op_t OP_RD = 2'b10;
    localparam op_t OP_RI = 2'b11;

    function automatic elem_t mk(input logic down, input logic two,
                                 input op_t a, input op_t b);
        elem_t e;
        e.down = down;
        e.two  = two;
        e.op0  = a;
        e.op1  = b;
        return e;
    endfunction

    function automatic elem_t elem_of(input algo_e a, input logic [ELEM_W-1:0] i);
        elem_t e;
        e = '0;
        case (a)
            ALG_INIT:  e = mk(1'b0, 1'b0, OP_WD, OP_WD);
            ALG_RDCHK: e = mk(1'b0, 1'b0, OP_RD, OP_RD);
            ALG_SCAN: begin
                case (i)
                    3'd0:    e = mk(1'b0, 1'b0, OP_WD, OP_WD);
                    3'd1:    e = mk(1'b0, 1'b0, OP_RD, OP_RD);
                    3'd2:    e = mk(1'b0, 1'b0, OP_WI, OP_WI);
                    default: e = mk(1'b0, 1'b0, OP_RI, OP_RI);
                endcase
            end
            ALG_MATS: begin
                case (i)
                    3'd0:    e = mk(1'b0, 1'b0, OP_WD, OP_WD);
                    3'd1:    e = mk(1'b0, 1'b1, OP_RD, OP_WI);
                    default: e = mk(1'b1, 1'b1, OP_RI, OP_WD);
                endcase
            end
            ALG_MARCHC: begin
                case (i)
                    3'd0:    e = mk(1'b0, 1'b0, OP_WD, OP_WD);
                    3'd1:    e = mk(1'b0, 1'b1, OP_RD, OP_WI);
                    3'd2:    e = mk(1'b0, 1'b1, OP_RI, OP_WD);
                    3'd3:    e = mk(1'b1, 1'b1, OP_RD, OP_WI);
                    3'd4:    e = mk(1'b1, 1'b1, OP_RI, OP_WD);
                    default: e = mk(1'b1, 1'b0, OP_RD, OP_RD);
                endcase
            end
            default: e = '0;
        endcase
        return e;
    endfunction

    function automatic logic [ELEM_W-1:0] last_elem(input algo_e a);
        case (a)
            ALG_SCAN:   return 3'd3;
            ALG_MATS:   return 3'd2;
            ALG_MARCHC: return 3'd5;
            default:    return 3'd0;
        endcase
    endfunction

    function automatic logic algo_ok(input logic [2:0] a);
        return a <= 3'd4;
    endfunction

    function automatic logic [3:0] cmd_needed(input algo_e a);
        return (a == ALG_RDCHK) ? CMD_RDCHK : CMD_WR;
    endfunction

    function automatic logic [3:0] cmd_of(input op_t o);
        return o.rd ? CMD_RDCHK : CMD_WR;
    endfunction
endpackage

// File: rtl/mbist_algo_table.sv
module mbist_algo_table
    import mbist_pkg::*;
(
    input  algo_e              algo,
    input  logic [ELEM_W-1:0]  idx,
    output elem_t              el,
    output logic [ELEM_W-1:0]  last_idx
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        el       = elem_of(algo, idx);
        last_idx = last_elem(algo);
    end
endmodule

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          inc,
    input  logic          dec,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] addr
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (load)
            addr <= load_val;
        else if (inc)
            addr <= addr + ONE;
        else if (dec)
            addr <= addr - ONE;
    end

    // R3: only one address action per cycle
    p_single_action_r3: assert property (@(posedge clk) disable iff (rst)
        !(load && (inc || dec)) && !(inc && dec));
endmodule

// File: rtl/mbist_compare.sv
module mbist_compare #(
    parameter int DW = 16
) (
    input  logic          en,
    input  logic          inv,
    input  logic [DW-1:0] bg,
    input  logic [DW-1:0] rdata,
    output logic          mismatch
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [DW-1:0] expect_w;
    logic [DW-1:0] diff;

    always_comb begin
        expect_w = inv ? ~bg : bg;
        diff     = expect_w ^ rdata;
        mismatch = en && (|diff);
    end
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
    import mbist_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    algo_sel,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] end_addr,
    input  logic [DW-1:0] background,
    input  logic [3:0]    init_cmd,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic          cmd_err,
    output logic [2:0]    step_elem,
    output logic          step_op,
    output logic [AW-1:0] step_addr,
    output logic [3:0]    step_cmd
);
    timeunit 1ns;
    timeprecision 1ps;

    state_e              state_q;
    algo_e               algo_q;
    logic [ELEM_W-1:0]   elem_q;
    logic                op_q;
    logic [AW-1:0]       lo_q, hi_q;
    logic [DW-1:0]       bg_q;
    logic                done_q, fail_q, err_q;
    logic [AW-1:0]       addr_q;

    elem_t               cur_el, nxt_el;
    logic [ELEM_W-1:0]   cur_last, nxt_last;
    algo_e               nxt_algo;
    logic [ELEM_W-1:0]   nxt_idx;
    op_t                 cur_op;

    logic accept, cmd_ok, range_ok, launch;
    logic last_op, at_last, adv, finish, mismatch;
    logic ag_load, ag_inc, ag_dec;
    logic [AW-1:0] ag_val;

    // start qualification
    always_comb begin
        accept   = start && (state_q == ST_IDLE);
        cmd_ok   = algo_ok(algo_sel) && (init_cmd == cmd_needed(algo_e'(algo_sel)));
        range_ok = (start_addr <= end_addr);
        launch   = accept && cmd_ok && range_ok;
    end

    // element lookup: current, and next (or first on launch)
    mbist_algo_table u_cur_tbl (
        .algo     (algo_q),
        .idx      (elem_q),
        .el       (cur_el),
        .last_idx (cur_last)
    );

    always_comb begin
        nxt_algo = (state_q == ST_IDLE) ? algo_e'(algo_sel) : algo_q;
        nxt_idx  = (state_q == ST_IDLE) ? '0 : elem_q + 3'd1;
    end

    mbist_algo_table u_nxt_tbl (
        .algo     (nxt_algo),
        .idx      (nxt_idx),
        .el       (nxt_el),
        .last_idx (nxt_last)
    );

    // step decode
    always_comb begin
        cur_op  = op_q ? cur_el.op1 : cur_el.op0;
        last_op = (op_q == cur_el.two);
        at_last = cur_el.down ? (addr_q == lo_q) : (addr_q == hi_q);
        adv     = ((state_q == ST_RUN) && !cur_op.rd) ||
                  ((state_q == ST_CHECK) && !mismatch);
        finish  = adv && last_op && at_last && (elem_q == cur_last);
    end

    mbist_compare #(.DW(DW)) u_cmp (
        .en       (state_q == ST_CHECK),
        .inv      (cur_op.inv),
        .bg       (bg_q),
        .rdata    (mem_rdata),
        .mismatch (mismatch)
    );

    // address control
    always_comb begin
        ag_load = launch || (adv && last_op && at_last && !finish);
        ag_inc  = adv && last_op && !at_last && !cur_el.down;
        ag_dec  = adv && last_op && !at_last &&  cur_el.down;
        if (launch)
            ag_val = nxt_el.down ? end_addr : start_addr;
        else
            ag_val = nxt_el.down ? hi_q : lo_q;
    end

    mbist_addr_gen #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (ag_load),
        .inc      (ag_inc),
        .dec      (ag_dec),
        .load_val (ag_val),
        .addr     (addr_q)
    );

    // sequencing state
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            algo_q  <= ALG_INIT;
            elem_q  <= '0;
            op_q    <= 1'b0;
            lo_q    <= '0;
            hi_q    <= '0;
            bg_q    <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            err_q   <= 1'b0;
        end else if (accept) begin
            done_q <= cmd_ok && !range_ok;
            fail_q <= 1'b0;
            err_q  <= !cmd_ok;
            if (launch) begin
                state_q <= ST_RUN;
                algo_q  <= algo_e'(algo_sel);
                elem_q  <= '0;
                op_q    <= 1'b0;
                lo_q    <= start_addr;
                hi_q    <= end_addr;
                bg_q    <= background;
            end
        end else if ((state_q == ST_RUN) && cur_op.rd) begin
            state_q <= ST_CHECK;
        end else if (mismatch) begin
            fail_q  <= 1'b1;
            state_q <= ST_IDLE;
        end else if (adv) begin
            if (!last_op) begin
                op_q <= 1'b1;
            end else begin
                op_q <= 1'b0;
                if (at_last && !finish)
                    elem_q <= elem_q + 3'd1;
            end
            if (finish) begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
            end else begin
                state_q <= ST_RUN;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = done_q;
        fail      = fail_q;
        cmd_err   = err_q;
        mem_addr  = addr_q;
        mem_we    = (state_q == ST_RUN) && !cur_op.rd;
        mem_re    = (state_q == ST_RUN) &&  cur_op.rd;
        mem_wdata = cur_op.inv ? ~bg_q : bg_q;
        step_elem = elem_q;
        step_op   = op_q;
        step_addr = addr_q;
        step_cmd  = cmd_of(cur_op);
    end

    // R11: no overlapping or idle accesses
    p_excl_access_r11: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_we && !mem_re));
    // R3: address inside the latched window
    p_in_window_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (addr_q >= lo_q) && (addr_q <= hi_q));
    // R2: address holds between operations of one element
    p_same_cell_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && !last_op) |=> $stable(addr_q));
    // R9: a compare cycle follows a read issue
    p_check_after_read_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK) |-> $past(mem_re));
    // R6: step state frozen after a halt
    p_halt_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> fail && $stable(step_addr) && $stable(step_elem)
                             && $stable(step_op) && $stable(step_cmd));
    // R8: outcome flags exclusive
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(done && fail));
    // R5: rejected start never runs
    p_err_idle_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> !busy);
endmodule

// File: tb/tb_mbist_seq.sv
module tb_mbist_seq;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [2:0]    algo_sel = '0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] end_addr = '0;
    logic [DW-1:0] background = '0;
    logic [3:0]    init_cmd = '0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we, mem_re;
    logic [DW-1:0] mem_rdata;
    logic          busy, done, fail, cmd_err;
    logic [2:0]    step_elem;
    logic          step_op;
    logic [AW-1:0] step_addr;
    logic [3:0]    step_cmd;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    mbist_seq #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst(rst), .start(start), .algo_sel(algo_sel),
        .start_addr(start_addr), .end_addr(end_addr), .background(background),
        .init_cmd(init_cmd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fail(fail), .cmd_err(cmd_err),
        .step_elem(step_elem), .step_op(step_op), .step_addr(step_addr),
        .step_cmd(step_cmd)
    );

    // RAM model with an optional stuck-at-0 bit mask on one address
    logic [DW-1:0] mem [DEPTH];
    logic          fault_en = 1'b0;
    logic [AW-1:0] fault_addr = '0;
    logic [DW-1:0] fault_mask = '0;
    logic          clr_cnt = 1'b0;
    int            wr_cnt, rd_cnt;

    always @(posedge clk) begin
        if (mem_we)
            mem[mem_addr] <= mem_wdata & ~((fault_en && mem_addr == fault_addr) ? fault_mask : '0);
        if (mem_re)
            mem_rdata <= mem[mem_addr];
        if (clr_cnt) begin
            wr_cnt <= 0;
            rd_cnt <= 0;
        end else begin
            if (mem_we) wr_cnt <= wr_cnt + 1;
            if (mem_re) rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] a, input logic [AW-1:0] lo,
                       input logic [AW-1:0] hi, input logic [DW-1:0] bg,
                       input logic [3:0] cmd, output int cyc);
        @(negedge clk);
        algo_sel = a; start_addr = lo; end_addr = hi;
        background = bg; init_cmd = cmd; start = 1'b1; clr_cnt = 1'b1;
        @(negedge clk);
        start = 1'b0; clr_cnt = 1'b0;
        cyc = 0;
        while (busy && cyc < 20000) begin
            cyc++;
            @(negedge clk);
        end
        if (cyc >= 20000) begin
            total++; bad++;
            $display("FAIL R8 watchdog: actual=busy expected=idle");
        end
    endtask

    typedef struct packed {
        logic [2:0]    algo;
        logic [AW-1:0] lo;
        logic [AW-1:0] hi;
        logic [DW-1:0] bg;
        logic [3:0]    cmd;
        logic [15:0]   wr;
        logic [15:0]   rd;
        logic          dn;
        logic          er;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 6'd0,  6'd63, 16'hA5A5, 4'h1, 16'd64,  16'd0,   1'b1, 1'b0},
        '{3'd1, 6'd0,  6'd63, 16'hA5A5, 4'h3, 16'd0,   16'd64,  1'b1, 1'b0},
        '{3'd2, 6'd0,  6'd63, 16'h3C3C, 4'h1, 16'd128, 16'd128, 1'b1, 1'b0},
        '{3'd3, 6'd0,  6'd63, 16'hF00F, 4'h1, 16'd192, 16'd128, 1'b1, 1'b0},
        '{3'd4, 6'd0,  6'd63, 16'h1234, 4'h1, 16'd320, 16'd320, 1'b1, 1'b0},
        '{3'd3, 6'd10, 6'd20, 16'hF00F, 4'h1, 16'd33,  16'd22,  1'b1, 1'b0},
        '{3'd0, 6'd0,  6'd63, 16'h0000, 4'h3, 16'd0,   16'd0,   1'b0, 1'b1},
        '{3'd1, 6'd0,  6'd63, 16'h0000, 4'h1, 16'd0,   16'd0,   1'b0, 1'b1},
        '{3'd5, 6'd0,  6'd63, 16'h0000, 4'h1, 16'd0,   16'd0,   1'b0, 1'b1},
        '{3'd2, 6'd30, 6'd20, 16'h0000, 4'h1, 16'd0,   16'd0,   1'b1, 1'b0},
        '{3'd4, 6'd5,  6'd5,  16'h1234, 4'h1, 16'd5,   16'd5,   1'b1, 1'b0}
    };

    initial begin
        #(5.0 * 200000);
        total++; bad++;
        $display("FAIL R8 global watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk(busy, 0, "R8 reset busy");
        chk(done, 0, "R8 reset done");
        chk(fail, 0, "R6 reset fail");
        chk(cmd_err, 0, "R5 reset cmd_err");
        chk(mem_we | mem_re, 0, "R11 reset access");

        // R1 R5 R7 R10 vector table
        for (int i = 0; i < NV; i++) begin
            run(VEC[i].algo, VEC[i].lo, VEC[i].hi, VEC[i].bg, VEC[i].cmd, cyc);
            chk(done, VEC[i].dn, $sformatf("R8 R10 vec%0d done", i));
            chk(cmd_err, VEC[i].er, $sformatf("R5 vec%0d cmd_err", i));
            chk(fail, 0, $sformatf("R4 vec%0d fail", i));
            chk(wr_cnt, VEC[i].wr, $sformatf("R1 R7 vec%0d writes", i));
            chk(rd_cnt, VEC[i].rd, $sformatf("R1 R7 vec%0d reads", i));
        end
        // R1 final contents written by March C- and the windowed MATS+
        chk(mem[0], 16'h1234, "R1 final data addr0");
        chk(mem[15], 16'hF00F, "R1 final data addr15");
        chk(mem[5], 16'h1234, "R1 final data addr5");
        repeat (3) @(negedge clk);
        chk(done, 1, "R8 done sticky");

        // R9 timing: Scan over 4 cells -> 6N busy cycles
        run(3'd2, 6'd0, 6'd3, 16'h00FF, 4'h1, cyc);
        chk(cyc, 24, "R9 scan busy cycles");

        // R4 read-and-check mismatch
        run(3'd0, 6'd0, 6'd63, 16'h0F0F, 4'h1, cyc);
        run(3'd1, 6'd0, 6'd63, 16'h0F0E, 4'h3, cyc);
        chk(fail, 1, "R4 rdchk fail");
        chk(done, 0, "R8 rdchk done cleared");
        chk(step_addr, 0, "R4 rdchk step_addr");
        chk(rd_cnt, 1, "R4 rdchk reads");

        // R6 R2 MATS+ stuck-at-0 in element 1
        fault_en = 1'b1; fault_addr = 6'd7; fault_mask = 16'h0001;
        run(3'd3, 6'd0, 6'd63, 16'hA5A5, 4'h1, cyc);
        chk(fail, 1, "R6 mats fail");
        chk(busy, 0, "R6 mats busy");
        chk(step_elem, 1, "R6 mats step_elem");
        chk(step_op, 0, "R6 mats step_op");
        chk(step_addr, 7, "R6 mats step_addr");
        chk(step_cmd, 3, "R6 mats step_cmd");
        chk(rd_cnt, 8, "R2 mats reads before halt");
        chk(wr_cnt, 71, "R2 mats writes before halt");
        repeat (5) @(negedge clk);
        chk(step_addr, 7, "R6 step_addr held");
        chk(mem_we | mem_re, 0, "R6 no access after halt");

        // R3 descending element reaches failing cell from the top
        fault_addr = 6'd20;
        run(3'd3, 6'd0, 6'd63, 16'h5A5A, 4'h1, cyc);
        chk(step_elem, 2, "R3 mats down step_elem");
        chk(step_addr, 20, "R3 mats down step_addr");
        chk(rd_cnt, 108, "R3 mats down reads");
        chk(wr_cnt, 171, "R3 mats down writes");

        // R6 March C- halt at element 2
        fault_addr = 6'd3;
        run(3'd4, 6'd0, 6'd15, 16'h5A5A, 4'h1, cyc);
        chk(fail, 1, "R6 marchc fail");
        chk(step_elem, 2, "R6 marchc step_elem");
        chk(step_addr, 3, "R6 marchc step_addr");
        chk(rd_cnt, 20, "R6 marchc reads");
        fault_en = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule